// File: doc/BRIEF.md
# Decade-Binary Sample-Rate Prescaler

This block turns a fast system clock into a periodic sample strobe, `sample_en`, which is high for one system clock per sample period. A base counter divides the system clock by `BASE_DIV` to produce the base rate. With the defaults, that is 10 MHz from a 100 MHz clock. A cascade of decade counters then divides the base rate by `DECADE_RATIO` per stage. A binary stage divides the chosen decade tick by a further power of two.

The rate is chosen by a 7-bit select code written through a simple write strobe. Bits [6:4] give the decade step `d` (0 to `NUM_DEC`) and bits [3:0] give the halving exponent `b` (0 to `BIN_MAX`). The sample period in system clocks is `BASE_DIV * DECADE_RATIO^d * 2^b`. Any code outside that range runs at the fallback code 64: decade 4, no halving, 1 kHz at the defaults. A written code is held as pending. It becomes active only at the terminal count of the period in progress, when every counter restarts from zero, so no shortened period is ever produced.

Control is a two-state machine. **COUNT** is the state in which the counters run. **FIRE** is the state in which `sample_en` is driven high. The transition COUNT→FIRE (*terminal*) happens when the selected decade tick arrives and the binary counter holds `2^b-1`. The transition FIRE→COUNT (*resume*) happens on the next clock. A synchronous reset enters COUNT.

Top module: `psc_sample_rate_gen`

## Requirements
- R1: While `rst` is high, `sample_en` is low. After release, the active code is 64, and the first pulse is seen after `BASE_DIV*DECADE_RATIO^4` rising edges, counted from the first edge with `rst` low.
- R2: Each `sample_en` pulse lasts exactly one system clock, and the next clock always has `sample_en` low.
- R3: Code 0 gives a period of `BASE_DIV` system clocks. In general, the period is `BASE_DIV * DECADE_RATIO^d * 2^b`, where `d` = code[6:4] and `b` = code[3:0].
- R4: Each increment of the low field code[3:0], from 0 up to `BIN_MAX`, doubles the period within a decade (codes 1, 2 and 65 to 68).
- R5: Each increment of the decade field code[6:4] multiplies the period by `DECADE_RATIO` (codes 16, 32, 48, 64, and the halved codes 17, 33, 49, 50).
- R6: A code with code[6:4] > `NUM_DEC` or code[3:0] > `BIN_MAX` (for example 15, 69, 80, 127) gives the same period as code 64.
- R7: A code written during a period does not change that period. The first full period after the next pulse uses the new code.
- R8: A reset discards any pending written code, and the block restarts at code 64.
- R9: While the code is unchanged, successive pulses are separated by a constant period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the select code |
| wr_code | input | 7 | Select code: [6:4] decade step, [3:0] halving exponent |
| sample_en | output | 1 | One-cycle sample strobe |

## Verification
The hardest case to reach is a code change that lands in the middle of a period. The old period must finish at full length, and the new period must start from counters that have been fully cleared. Higher decade counters could otherwise carry stale counts from the previous code. The bench writes the new code on the first clock after a pulse, when the counters are furthest from terminal count. It counts the cycles to the next pulse against the old period, and then the cycles to the following pulse against the new period. To keep the slowest codes short, the bench builds the block with a small base divisor and decade ratio.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int CODE_W = 7;
    localparam int DEC_FW = 3;
    localparam int BIN_FW = 4;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_FIRE  = 1'b1
    } psc_state_e;

    typedef struct packed {
        logic [DEC_FW-1:0] dec;
        logic [BIN_FW-1:0] bin;
    } rate_sel_t;
endpackage

// File: rtl/psc_mod_counter.sv
module psc_mod_counter #(
    parameter int MODULUS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (MODULUS > 2) ? $clog2(MODULUS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);

    // R3: the count never leaves its modulus
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/psc_code_decode.sv
module psc_code_decode
    import psc_pkg::*;
#(
    parameter int NUM_DEC = 4,
    parameter int BIN_MAX = 4,
    parameter logic [CODE_W-1:0] FALLBACK_CODE = 7'd64
) (
    input  logic [CODE_W-1:0] code,
    output rate_sel_t         sel
);
    logic [DEC_FW-1:0] dec_f;
    logic [BIN_FW-1:0] bin_f;
    logic              ok;

    always_comb begin
        dec_f = code[CODE_W-1 -: DEC_FW];
        bin_f = code[BIN_FW-1:0];
        ok    = (32'(dec_f) <= NUM_DEC) && (32'(bin_f) <= BIN_MAX);
        if (ok) begin
            sel.dec = dec_f;
            sel.bin = bin_f;
        end else begin
            sel.dec = FALLBACK_CODE[CODE_W-1 -: DEC_FW];
            sel.bin = FALLBACK_CODE[BIN_FW-1:0];
        end
    end
endmodule

// File: rtl/psc_sample_rate_gen.sv
module psc_sample_rate_gen
    import psc_pkg::*;
#(
    parameter int BASE_DIV = 10,
    parameter int DECADE_RATIO = 10,
    parameter int NUM_DEC = 4,
    parameter int BIN_MAX = 4,
    parameter logic [6:0] FALLBACK_CODE = 7'd64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [6:0] wr_code,
    output logic       sample_en
);
    localparam int BW = (BIN_MAX > 0) ? BIN_MAX : 1;
    localparam rate_sel_t FB_SEL = '{dec: FALLBACK_CODE[6:4], bin: FALLBACK_CODE[3:0]};

    psc_state_e        state, state_nx;
    logic [CODE_W-1:0] pend_code;
    rate_sel_t         pend_sel, act_sel;
    logic [NUM_DEC:0]  ticks;
    logic              sel_tick, terminal;
    logic [BW-1:0]     bcnt, bin_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_code <= FALLBACK_CODE;
        end else if (wr_en) begin
            pend_code <= wr_code;
        end
    end

    psc_code_decode #(
        .NUM_DEC(NUM_DEC), .BIN_MAX(BIN_MAX), .FALLBACK_CODE(FALLBACK_CODE)
    ) u_decode (
        .code(pend_code),
        .sel (pend_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_sel <= FB_SEL;
        end else if (terminal) begin
            act_sel <= pend_sel;
        end
    end

    psc_mod_counter #(.MODULUS(BASE_DIV)) u_base (
        .clk(clk), .rst(rst), .clr(terminal), .en(1'b1), .tick(ticks[0])
    );

    for (genvar gi = 1; gi <= NUM_DEC; gi++) begin : g_decade
        psc_mod_counter #(.MODULUS(DECADE_RATIO)) u_dec (
            .clk(clk), .rst(rst), .clr(terminal), .en(ticks[gi-1]), .tick(ticks[gi])
        );
    end

    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i <= NUM_DEC; i++) begin
            if (act_sel.dec == DEC_FW'(i)) sel_tick = ticks[i];
        end
        bin_last = BW'((32'd1 << act_sel.bin) - 32'd1);
        terminal = sel_tick && (bcnt == bin_last);
    end

    always_ff @(posedge clk) begin
        if (rst || terminal) begin
            bcnt <= '0;
        end else if (sel_tick) begin
            bcnt <= bcnt + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_COUNT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COUNT: if (terminal) state_nx = ST_FIRE;
            ST_FIRE:  state_nx = terminal ? ST_FIRE : ST_COUNT;
            default:  state_nx = ST_COUNT;
        endcase
    end

    // outputs
    always_comb begin
        sample_en = (state == ST_FIRE);
    end

    // R2: one-cycle strobe
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> !sample_en);
    // R3: pulse exactly one cycle after terminal count
    a_r3_fire_after_terminal: assert property (@(posedge clk) disable iff (rst)
        terminal |=> sample_en);
    a_r3_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
        !terminal |=> !sample_en);
    a_r3_bin_restart: assert property (@(posedge clk) disable iff (rst)
        terminal |=> (bcnt == '0));
    // R6: active selection always within the supported range
    a_r6_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        (32'(act_sel.dec) <= NUM_DEC) && (32'(act_sel.bin) <= BIN_MAX));
    // R7: active selection changes only at terminal count
    a_r7_sel_held: assert property (@(posedge clk) disable iff (rst)
        !terminal |=> $stable(act_sel));
endmodule

// File: tb/psc_sample_rate_gen_test.sv
module psc_sample_rate_gen_test;
    localparam int BASE = 4;
    localparam int RATIO = 3;
    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [6:0] wr_code = '0;
    logic       sample_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    psc_sample_rate_gen #(
        .BASE_DIV(BASE), .DECADE_RATIO(RATIO), .NUM_DEC(4), .BIN_MAX(4), .FALLBACK_CODE(7'd64)
    ) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .sample_en(sample_en)
    );

    function automatic int exp_period(int code);
        int d = code >> 4;
        int b = code & 15;
        int p = BASE;
        if (d > 4 || b > 4) begin
            d = 4;
            b = 0;
        end
        for (int i = 0; i < d; i++) p = p * RATIO;
        return p * (1 << b);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // counts rising edges until sample_en is seen; flags a wide pulse
    task automatic next_pulse(output int n, output bit wide);
        n = 0;
        wide = 1'b0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            wr_en = 1'b0;
            if (n == 1 && sample_en) wide = 1'b1;
            if (sample_en) break;
            if (n > 60000) break;
        end
    endtask

    task automatic write_code(input int code);
        @(negedge clk);
        wr_en = 1'b1;
        wr_code = 7'(code);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        int n;
        bit w;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sample_en == 1'b0, "R1 low in reset", sample_en, 0);
        rst = 1'b0;
        next_pulse(n, w);
        check(n == exp_period(64), "R1 first pulse", n, exp_period(64));
    endtask

    task automatic t_rate(input int code, input string req);
        int n1, n2;
        bit w1, w2;
        write_code(code);
        next_pulse(n1, w1);
        next_pulse(n1, w1);
        next_pulse(n2, w2);
        check(n1 == exp_period(code), req, n1, exp_period(code));
        check(n2 == n1, "R9 steady period", n2, n1);
        check(!w1 && !w2, "R2 one-cycle pulse", int'(w1 | w2), 0);
    endtask

    task automatic t_midperiod_change(input int old_code, input int new_code);
        int n;
        bit w;
        write_code(old_code);
        next_pulse(n, w);
        next_pulse(n, w);
        wr_en = 1'b1;
        wr_code = 7'(new_code);
        next_pulse(n, w);
        check(n == exp_period(old_code), "R7 period in progress kept", n, exp_period(old_code));
        next_pulse(n, w);
        check(n == exp_period(new_code), "R7 new code after pulse", n, exp_period(new_code));
    endtask

    task automatic t_reset_discards;
        int n;
        bit w;
        write_code(0);
        write_code(2);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        next_pulse(n, w);
        check(n == exp_period(64), "R8 reset restores 64", n, exp_period(64));
        next_pulse(n, w);
        check(n == exp_period(64), "R8 pending write dropped", n, exp_period(64));
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_rate(0, "R3 code 0");
                t_rate(1, "R4 code 1");
                t_rate(2, "R4 code 2");
                t_rate(16, "R5 code 16");
                t_rate(32, "R5 code 32");
                t_rate(48, "R5 code 48");
                t_rate(17, "R5 code 17");
                t_rate(33, "R5 code 33");
                t_rate(49, "R5 code 49");
                t_rate(50, "R5 code 50");
                t_rate(64, "R5 code 64");
                t_rate(65, "R4 code 65");
                t_rate(66, "R4 code 66");
                t_rate(67, "R4 code 67");
                t_rate(68, "R4 code 68");
                t_rate(69, "R6 code 69");
                t_rate(80, "R6 code 80");
                t_rate(127, "R6 code 127");
                t_rate(15, "R6 code 15");
                t_midperiod_change(48, 1);
                t_midperiod_change(0, 33);
                t_reset_discards();
            end
            begin
                wait (cycles >= WD_LIMIT);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) check(1'b0, "watchdog", cycles, WD_LIMIT);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule